// File: doc/BRIEF.md
# Channel Control Register Bank

This block holds the host-visible control state of one bus-controller channel. It sits on a simple 32-bit host bus and claims one 4 KB window. The window index is `CHAN_IDX + 1`, because window 0 belongs to the system control area and the channel windows are stacked after it. The outputs drive the DMA and interrupt logic next to it:
- the receive and transmit control words,
- the clock source and divider selection, with the resulting frequency in MHz,
- a timestamp-reset level,
- the receive limits word,
- a receive acknowledge strobe carrying a 4-bit tag,
- a 64-bit command pulse,
- a saturating count of transmit frames still pending.

The receive and transmit control words are never written whole. Software ORs bits in through a set alias and removes bits through a clear alias, so a bit can change without a read-modify-write. The 64-bit command arrives as two 32-bit writes, low word first. The command leaves the block as one pulse, issued only when the high word lands. Each write to the transmit request accumulator adds its value to the pending count. The transmit engine takes one off that count for every frame it consumes.

Top module: `chan_reg_bank`

## Requirements
- R1: After reset, both control words read 0x0002_0000 (bit 17, DMA hold, set; bit 16 uncached and bit 18 interrupt enable clear). The clock select is 0 and reports 80 MHz. The pending count is 0, the timestamp reset is 0, and no strobe is active.
- R2: A write to a set alias ORs the written value into its control word. The transmit set alias is at offset 0x30 and the receive set alias is at 0x50. The new word appears on the output in the cycle after the write.
- R3: A write to a clear alias clears every bit of its control word that is 1 in the written value. The transmit clear alias is at 0x38 and the receive clear alias is at 0x58. A read of either alias of a word returns the current control word.
- R4: The clock select register is at offset 0x08. Bit 3 = 0 selects the 80 MHz source. Bit 3 = 1 selects the 240 MHz source, where bits 2:0 codes 0 to 4 give 60, 40, 30, 24 and 20 MHz and codes 5 to 7 fall back to 80. The stored bits 3:0 read back.
- R5: A write to offset 0x10 stores the low command word and issues nothing. A write to offset 0x14 raises `cmd_valid` for exactly one cycle, with `cmd_data` = {high word, last low word}. Reads of either command offset return 0.
- R6: A write to offset 0x20 adds the written value to the pending count. Each `tx_frame_done` cycle subtracts one. Both can happen in the same cycle. A read of 0x20 returns the count.
- R7: The pending count saturates at 2^CNT_W−1 instead of wrapping, and it stays at 0 when a frame-done pulse arrives at 0.
- R8: Writes whose address lies outside this channel's window, or at an unmapped offset inside it, change no output. Reads of unmapped offsets return 0.
- R9: Offset 0x00 bit 0 drives `ts_reset` and reads back.
- R10: The word written at offset 0x60 appears on `rx_limits` and reads back. A write at offset 0x68 pulses `rx_ack_valid` for one cycle with `rx_ack_tag` = written bits 3:0. A read of 0x68 returns the last tag.
- R11: A read returns its data on `bus_rdata` with `bus_rvalid` high in the cycle after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host write request |
| bus_rd | input | 1 | Host read request |
| bus_addr | input | ADDR_W | Byte address on the host bus |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| tx_frame_done | input | 1 | Transmit engine consumed one frame |
| ts_reset | output | 1 | Timestamp counter reset level |
| clk_src_fast | output | 1 | 1 = 240 MHz source selected |
| clk_div | output | 3 | Divider code for the fast source |
| clk_mhz | output | 8 | Resulting channel clock in MHz |
| rx_ctl | output | 32 | Receive control word |
| tx_ctl | output | 32 | Transmit control word |
| rx_limits | output | 32 | Receive count/time limits word |
| rx_ack_valid | output | 1 | One-cycle receive acknowledge strobe |
| rx_ack_tag | output | 4 | Tag delivered with the acknowledge |
| cmd_valid | output | 1 | One-cycle command pulse |
| cmd_data | output | 64 | Assembled command |
| tx_pending | output | CNT_W | Pending transmit frame count |

## Verification
A wrong control word shows on `rx_ctl` or `tx_ctl` in the cycle right after the alias write that caused it. A read of either alias shows it again one cycle after the read. A low command half that was lost or stale shows only when the high half is written, as a wrong upper or lower word on `cmd_data` during the single pulse cycle. A pending count that wraps instead of saturating, or that underflows, shows on `tx_pending` at once. The bench drives the count to both limits on purpose so that these cases appear.

// File: rtl/chan_reg_pkg.sv
package chan_reg_pkg;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_MISC,
        SEL_CLKSEL,
        SEL_CMD_LO,
        SEL_CMD_HI,
        SEL_TXREQ,
        SEL_TX_SET,
        SEL_TX_CLR,
        SEL_RX_SET,
        SEL_RX_CLR,
        SEL_RX_LIM,
        SEL_RX_ACK
    } reg_sel_e;

    localparam int WIN_BITS = 12;

    // control word bit positions
    localparam int CTL_UNCACHED = 16;
    localparam int CTL_DMA_HOLD = 17;
    localparam int CTL_IRQ_EN   = 18;
    localparam logic [31:0] CTL_RESET_VAL = 32'h1 << CTL_DMA_HOLD;

    typedef struct packed {
        logic       fast;
        logic [2:0] div;
    } clk_sel_t;

    function automatic reg_sel_e decode_offset(input logic [WIN_BITS-1:0] off);
        case (off)
            12'h000: decode_offset = SEL_MISC;
            12'h008: decode_offset = SEL_CLKSEL;
            12'h010: decode_offset = SEL_CMD_LO;
            12'h014: decode_offset = SEL_CMD_HI;
            12'h020: decode_offset = SEL_TXREQ;
            12'h030: decode_offset = SEL_TX_SET;
            12'h038: decode_offset = SEL_TX_CLR;
            12'h050: decode_offset = SEL_RX_SET;
            12'h058: decode_offset = SEL_RX_CLR;
            12'h060: decode_offset = SEL_RX_LIM;
            12'h068: decode_offset = SEL_RX_ACK;
            default: decode_offset = SEL_NONE;
        endcase
    endfunction

    function automatic logic [7:0] clk_sel_mhz(input clk_sel_t s);
        if (!s.fast) begin
            clk_sel_mhz = 8'd80;
        end else begin
            case (s.div)
                3'd0:    clk_sel_mhz = 8'd60;
                3'd1:    clk_sel_mhz = 8'd40;
                3'd2:    clk_sel_mhz = 8'd30;
                3'd3:    clk_sel_mhz = 8'd24;
                3'd4:    clk_sel_mhz = 8'd20;
                default: clk_sel_mhz = 8'd80;
            endcase
        end
    endfunction

endpackage

// File: rtl/chan_ctl_word.sv
module chan_ctl_word #(
    parameter int          WIDTH     = 32,
    parameter logic [31:0] RESET_VAL = 32'h0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_we,
    input  logic             clr_we,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] word
);

    always_ff @(posedge clk) begin
        if (rst) begin
            word <= RESET_VAL[WIDTH-1:0];
        end else if (set_we) begin
            word <= word | wdata;
        end else if (clr_we) begin
            word <= word & ~wdata;
        end
    end

    // R2
    set_bits_chk: assert property (@(posedge clk) disable iff (rst)
        set_we |=> ((word & $past(wdata)) == $past(wdata)));

    // R3
    clr_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_we && !set_we) |=> ((word & $past(wdata)) == '0));

endmodule

// File: rtl/chan_cmd_port.sv
module chan_cmd_port #(
    parameter int HALF_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic [HALF_W-1:0] wdata,
    output logic              cmd_valid,
    output logic [2*HALF_W-1:0] cmd_data
);

    logic [HALF_W-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q      <= '0;
            cmd_valid <= 1'b0;
            cmd_data  <= '0;
        end else begin
            cmd_valid <= hi_we;
            if (lo_we) begin
                lo_q <= wdata;
            end
            if (hi_we) begin
                cmd_data <= {wdata, lo_q};
            end
        end
    end

    // R5
    lo_no_issue_chk: assert property (@(posedge clk) disable iff (rst)
        (lo_we && !hi_we) |=> !cmd_valid);

    // R5
    hi_word_chk: assert property (@(posedge clk) disable iff (rst)
        hi_we |=> (cmd_valid && cmd_data[2*HALF_W-1:HALF_W] == $past(wdata)));

endmodule

// File: rtl/chan_txreq_count.sv
module chan_txreq_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             add_we,
    input  logic [31:0]      add_val,
    input  logic             dec,
    output logic [CNT_W-1:0] count
);

    localparam int SUM_W = (CNT_W > 32 ? CNT_W : 32) + 2;
    localparam logic [SUM_W-1:0] MAX_VAL = {{(SUM_W-CNT_W){1'b0}}, {CNT_W{1'b1}}};

    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] next;

    always_comb begin
        sum = SUM_W'(count) + (add_we ? SUM_W'(add_val) : '0);
        if (dec && sum != '0) begin
            next = sum - 1'b1;
        end else begin
            next = sum;
        end
        if (next > MAX_VAL) begin
            next = MAX_VAL;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            count <= next[CNT_W-1:0];
        end
    end

    // R7
    sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (count == {CNT_W{1'b1}} && !dec) |=> count == {CNT_W{1'b1}});

    // R7
    floor_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (count == '0 && !add_we) |=> count == '0);

    // R6
    dec_step_chk: assert property (@(posedge clk) disable iff (rst)
        (dec && !add_we && count != '0) |=> count == $past(count) - 1'b1);

endmodule

// File: rtl/chan_reg_bank.sv
module chan_reg_bank
    import chan_reg_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int CHAN_IDX = 0,
    parameter int CNT_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    input  logic              tx_frame_done,
    output logic              ts_reset,
    output logic              clk_src_fast,
    output logic [2:0]        clk_div,
    output logic [7:0]        clk_mhz,
    output logic [31:0]       rx_ctl,
    output logic [31:0]       tx_ctl,
    output logic [31:0]       rx_limits,
    output logic              rx_ack_valid,
    output logic [3:0]        rx_ack_tag,
    output logic              cmd_valid,
    output logic [63:0]       cmd_data,
    output logic [CNT_W-1:0]  tx_pending
);

    localparam int WIN_IDX_W = ADDR_W - WIN_BITS;
    localparam logic [WIN_IDX_W-1:0] MY_WIN = WIN_IDX_W'(CHAN_IDX + 1);

    logic     in_win;
    reg_sel_e sel;
    logic     we;
    clk_sel_t clk_sel_q;

    assign in_win = (bus_addr[ADDR_W-1:WIN_BITS] == MY_WIN);
    assign sel    = in_win ? decode_offset(bus_addr[WIN_BITS-1:0]) : SEL_NONE;
    assign we     = bus_wr;

    chan_ctl_word #(.WIDTH(32), .RESET_VAL(CTL_RESET_VAL)) u_tx_ctl (
        .clk    (clk),
        .rst    (rst),
        .set_we (we && sel == SEL_TX_SET),
        .clr_we (we && sel == SEL_TX_CLR),
        .wdata  (bus_wdata),
        .word   (tx_ctl)
    );

    chan_ctl_word #(.WIDTH(32), .RESET_VAL(CTL_RESET_VAL)) u_rx_ctl (
        .clk    (clk),
        .rst    (rst),
        .set_we (we && sel == SEL_RX_SET),
        .clr_we (we && sel == SEL_RX_CLR),
        .wdata  (bus_wdata),
        .word   (rx_ctl)
    );

    chan_cmd_port #(.HALF_W(32)) u_cmd (
        .clk       (clk),
        .rst       (rst),
        .lo_we     (we && sel == SEL_CMD_LO),
        .hi_we     (we && sel == SEL_CMD_HI),
        .wdata     (bus_wdata),
        .cmd_valid (cmd_valid),
        .cmd_data  (cmd_data)
    );

    chan_txreq_count #(.CNT_W(CNT_W)) u_txreq (
        .clk     (clk),
        .rst     (rst),
        .add_we  (we && sel == SEL_TXREQ),
        .add_val (bus_wdata),
        .dec     (tx_frame_done),
        .count   (tx_pending)
    );

    // plain registers: misc, clock select, limits, acknowledge
    always_ff @(posedge clk) begin
        if (rst) begin
            ts_reset     <= 1'b0;
            clk_sel_q    <= '0;
            rx_limits    <= '0;
            rx_ack_valid <= 1'b0;
            rx_ack_tag   <= '0;
        end else begin
            rx_ack_valid <= we && sel == SEL_RX_ACK;
            if (we) begin
                case (sel)
                    SEL_MISC:   ts_reset   <= bus_wdata[0];
                    SEL_CLKSEL: clk_sel_q  <= clk_sel_t'(bus_wdata[3:0]);
                    SEL_RX_LIM: rx_limits  <= bus_wdata;
                    SEL_RX_ACK: rx_ack_tag <= bus_wdata[3:0];
                    default: ;
                endcase
            end
        end
    end

    assign clk_src_fast = clk_sel_q.fast;
    assign clk_div      = clk_sel_q.div;
    assign clk_mhz      = clk_sel_mhz(clk_sel_q);

    // read path
    logic [31:0] rd_mux;

    always_comb begin
        case (sel)
            SEL_MISC:               rd_mux = {31'b0, ts_reset};
            SEL_CLKSEL:             rd_mux = {28'b0, clk_sel_q};
            SEL_TXREQ:              rd_mux = 32'(tx_pending);
            SEL_TX_SET, SEL_TX_CLR: rd_mux = tx_ctl;
            SEL_RX_SET, SEL_RX_CLR: rd_mux = rx_ctl;
            SEL_RX_LIM:             rd_mux = rx_limits;
            SEL_RX_ACK:             rd_mux = {28'b0, rx_ack_tag};
            default:                rd_mux = 32'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= bus_rd;
            bus_rdata  <= bus_rd ? rd_mux : 32'b0;
        end
    end

    // R4
    clk_legal_chk: assert property (@(posedge clk) disable iff (rst)
        clk_mhz inside {8'd20, 8'd24, 8'd30, 8'd40, 8'd60, 8'd80});

    // R10
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_ack_valid && !(we && sel == SEL_RX_ACK)) |=> !rx_ack_valid);

    // R11
    rvalid_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> bus_rvalid);

endmodule

// File: tb/chan_reg_bank_test.sv
module chan_reg_bank_test;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16;
    localparam int CNT_W  = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_rvalid;
    logic              tx_frame_done = 1'b0;
    logic              ts_reset;
    logic              clk_src_fast;
    logic [2:0]        clk_div;
    logic [7:0]        clk_mhz;
    logic [31:0]       rx_ctl, tx_ctl, rx_limits;
    logic              rx_ack_valid;
    logic [3:0]        rx_ack_tag;
    logic              cmd_valid;
    logic [63:0]       cmd_data;
    logic [CNT_W-1:0]  tx_pending;

    int total = 0;
    int bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    chan_reg_bank #(.ADDR_W(ADDR_W), .CHAN_IDX(0), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .tx_frame_done(tx_frame_done),
        .ts_reset(ts_reset), .clk_src_fast(clk_src_fast), .clk_div(clk_div),
        .clk_mhz(clk_mhz), .rx_ctl(rx_ctl), .tx_ctl(tx_ctl),
        .rx_limits(rx_limits), .rx_ack_valid(rx_ack_valid),
        .rx_ack_tag(rx_ack_tag), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
        .tx_pending(tx_pending)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // all tasks start and end on a falling edge
    task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input string req, input logic [15:0] a, input logic [31:0] exp);
        exp_q.push_back(exp);
        tag_q.push_back(req);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic frame_done();
        tx_frame_done = 1'b1;
        @(negedge clk);
        tx_frame_done = 1'b0;
    endtask

    // monitor: compares read data with the scoreboard
    always @(negedge clk) begin
        if (!rst && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R11 actual=%0h expected=no read", bus_rdata);
            end else begin
                check(tag_q.pop_front(), {32'b0, bus_rdata}, {32'b0, exp_q.pop_front()});
            end
        end
    end

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 tx_ctl", tx_ctl, 32'h0002_0000);
        check("R1 rx_ctl", rx_ctl, 32'h0002_0000);
        check("R1 clk_mhz", clk_mhz, 8'd80);
        check("R1 pending", tx_pending, 0);
        check("R1 strobes", {cmd_valid, rx_ack_valid, ts_reset}, 0);

        // R2 / R3 transmit word
        bus_write(16'h1030, 32'h0004_0000);
        check("R2 tx set", tx_ctl, 32'h0006_0000);
        bus_read("R3 tx clr alias read", 16'h1038, 32'h0006_0000);
        bus_write(16'h1038, 32'h0002_0000);
        check("R3 tx clear", tx_ctl, 32'h0004_0000);
        // R2 / R3 receive word
        bus_write(16'h1050, 32'h0001_0000);
        check("R2 rx set", rx_ctl, 32'h0003_0000);
        bus_write(16'h1058, 32'h0003_0000);
        check("R3 rx clear", rx_ctl, 32'h0000_0000);
        bus_read("R3 rx set alias read", 16'h1050, 32'h0);

        // R4 clock decode
        bus_write(16'h1008, 32'h8); check("R4 code8", clk_mhz, 8'd60);
        check("R4 fields", {clk_src_fast, clk_div}, 4'h8);
        bus_write(16'h1008, 32'h9); check("R4 code9", clk_mhz, 8'd40);
        bus_write(16'h1008, 32'hA); check("R4 codeA", clk_mhz, 8'd30);
        bus_write(16'h1008, 32'hB); check("R4 codeB", clk_mhz, 8'd24);
        bus_write(16'h1008, 32'hC); check("R4 codeC", clk_mhz, 8'd20);
        bus_write(16'h1008, 32'hD); check("R4 fallback", clk_mhz, 8'd80);
        bus_read("R4 readback", 16'h1008, 32'hD);
        bus_write(16'h1008, 32'h3); check("R4 slow src", clk_mhz, 8'd80);

        // R5 command port
        bus_write(16'h1010, 32'hCAFE_0001);
        check("R5 low no pulse", cmd_valid, 1'b0);
        bus_write(16'h1014, 32'h1234_5678);
        check("R5 pulse", cmd_valid, 1'b1);
        check("R5 data", cmd_data, 64'h1234_5678_CAFE_0001);
        @(negedge clk);
        check("R5 one cycle", cmd_valid, 1'b0);
        bus_read("R5 read zero", 16'h1010, 32'h0);
        bus_read("R5 read zero hi", 16'h1014, 32'h0);

        // R6 accumulator
        bus_write(16'h1020, 32'd3);
        bus_write(16'h1020, 32'd2);
        check("R6 add", tx_pending, 16'd5);
        frame_done();
        check("R6 dec", tx_pending, 16'd4);
        tx_frame_done = 1'b1;
        bus_write(16'h1020, 32'd1);
        tx_frame_done = 1'b0;
        check("R6 add and dec", tx_pending, 16'd4);
        bus_read("R6 read count", 16'h1020, 32'd4);

        // R7 floor and ceiling
        repeat (4) frame_done();
        frame_done();
        check("R7 floor", tx_pending, 16'd0);
        bus_write(16'h1020, 32'hFFFF_FFFF);
        check("R7 saturate", tx_pending, 16'hFFFF);
        bus_write(16'h1020, 32'd5);
        check("R7 stay max", tx_pending, 16'hFFFF);
        frame_done();
        check("R7 below max", tx_pending, 16'hFFFE);

        // R8 foreign windows and unmapped offsets
        bus_write(16'h2030, 32'h0001_0000);
        bus_write(16'h0030, 32'h0001_0000);
        bus_write(16'h1034, 32'h0001_0000);
        check("R8 tx untouched", tx_ctl, 32'h0004_0000);
        bus_write(16'h2014, 32'h1);
        check("R8 no cmd", cmd_valid, 1'b0);
        bus_read("R8 unmapped read", 16'h1004, 32'h0);

        // R9 misc
        bus_write(16'h1000, 32'h1);
        check("R9 ts_reset", ts_reset, 1'b1);
        bus_read("R9 readback", 16'h1000, 32'h1);

        // R10 limits and acknowledge
        bus_write(16'h1060, 32'h0000_0A10);
        check("R10 limits", rx_limits, 32'h0000_0A10);
        bus_write(16'h1068, 32'h0000_00F5);
        check("R10 ack", {rx_ack_valid, rx_ack_tag}, 5'h15);
        @(negedge clk);
        check("R10 ack one cycle", rx_ack_valid, 1'b0);
        bus_read("R10 tag read", 16'h1068, 32'h5);

        @(negedge clk);
        check("R11 reads drained", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule